// File: doc/BRIEF.md
# EEPROM Write-Protection Arbiter

This block sits between the command decoder of a serial EEPROM and its internal write timer. It decides whether a write request may start a programming cycle. Array writes and status-register writes have separate permission paths. An array write needs the software write-enable latch set, an idle write engine, and a target address outside the region locked by the two block-protect bits. A status-register write needs the latch and an idle engine too. It can also be vetoed by the external write-protect pin, but only when the status enable bit for that pin is set.

A status write is armed while the device is selected and is committed when the device is deselected. If the write-protect pin falls while the write is still armed, and the pin function is enabled, the armed write is cancelled and an abort pulse is raised. Once the internal write has started, pin activity no longer affects it. Any write attempt that reaches the permission stage clears the write-enable latch, whether the write is allowed or dropped. The array depth and the depth of the pin synchronizer are parameters.

Top module: `eeprom_wr_guard`

## Requirements
- R1: During and after reset, every output is low and no status write is armed.
- R2: An array request with `wel_i`=1, `busy_i`=0 and an address outside the locked region gives exactly one `arr_allow_o` pulse and one `wel_clr_o` pulse, both one cycle after the request.
- R3: `bp_i` encoding: 00 locks nothing, 01 locks addresses >= 3/4 of DEPTH, 10 locks addresses >= DEPTH/2, 11 locks every address. A request to a locked address gives no `arr_allow_o`. It gives one `arr_drop_o` pulse and still one `wel_clr_o` pulse.
- R4: With `wel_i`=0, array and status requests are refused. No allow pulse and no `wel_clr_o` pulse follow.
- R5: A status arm (`sr_arm_i` while `sel_i`=1, `wel_i`=1, permitted) gives no `sr_allow_o` while the device stays selected. It gives exactly one `sr_allow_o` pulse after `sel_i` falls.
- R6: With `wpen_i`=1 and the synchronized `wp_ni` low, a status arm is refused: no `sr_allow_o` on deselect, but `wel_clr_o` still pulses. With `wp_ni` high, the same arm is accepted.
- R7: With `wpen_i`=0, `wp_ni` has no effect. An arm with the pin low is accepted, and a pin fall during an armed write causes no abort.
- R8: With `wpen_i`=1, a fall of `wp_ni` while a status write is armed and the device is selected gives one `sr_abort_o` pulse. No `sr_allow_o` follows on deselect.
- R9: While `busy_i`=1, every array and status request is refused with no `wel_clr_o` pulse, and a `wp_ni` fall gives no abort.
- R10: Range boundaries are exact. Under level 01 the address 3/4·DEPTH−1 is allowed, and under level 10 the address DEPTH/2−1 is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Device selected (transaction open) |
| wel_i | input | 1 | Write-enable latch state |
| bp_i | input | 2 | Block-protect level |
| wpen_i | input | 1 | Status bit that enables the write-protect pin |
| wp_ni | input | 1 | Write-protect pin, active low, asynchronous |
| busy_i | input | 1 | Internal write cycle running |
| arr_req_i | input | 1 | Array write request pulse |
| addr_i | input | ADDR_W | Array write target address |
| sr_arm_i | input | 1 | Status write request pulse |
| arr_allow_o | output | 1 | Start array write cycle |
| arr_drop_o | output | 1 | Array write dropped by range lock |
| sr_allow_o | output | 1 | Start status write cycle |
| sr_abort_o | output | 1 | Armed status write cancelled by pin |
| wel_clr_o | output | 1 | Clear the write-enable latch |

## Verification
The bench probes each lock level exactly at its boundary address and one below it. A comparator off by one, or one that decodes the wrong bit, would then let a locked byte through or drop a free one. It checks that the write-enable latch is cleared on a dropped write; a design that clears only on success would leave the latch set. It separates a pin that vetoes an arm from a pin fall that aborts an armed write, and repeats both with the pin function disabled. A design that ignores the enable bit would abort or refuse there. It also raises a pin fall after the write has been committed and the engine is busy, where a spurious abort would wrongly appear.

// File: rtl/wr_guard_pkg.sv
package wr_guard_pkg;
  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_lvl_e;

  typedef enum logic {
    SR_IDLE,
    SR_ARMED
  } sr_state_e;
endpackage

// File: rtl/wr_range_lock.sv
module wr_range_lock
  import wr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  prot_lvl_e         lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);
  localparam int unsigned DEPTH     = 1 << ADDR_W;
  localparam logic [ADDR_W:0] QTR_BASE  = (ADDR_W+1)'(DEPTH - DEPTH / 4);
  localparam logic [ADDR_W:0] HALF_BASE = (ADDR_W+1)'(DEPTH / 2);

  logic [ADDR_W:0] addr_ext;
  logic            in_qtr, in_half;

  assign addr_ext = {1'b0, addr_i};
  assign in_qtr   = addr_ext >= QTR_BASE;
  assign in_half  = addr_ext >= HALF_BASE;

  always_comb begin
    unique case (lvl_i)
      PROT_NONE: locked_o = 1'b0;
      PROT_QTR:  locked_o = in_qtr;
      PROT_HALF: locked_o = in_half;
      default:   locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wr_pin_sync.sv
module wr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic lvl_no,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= pin_ni;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], pin_ni};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign lvl_no = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];

  AST_FALL_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> $past(lvl_no)); // R8
endmodule

// File: rtl/wr_sr_ctrl.sv
module wr_sr_ctrl
  import wr_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic arm_i,
  input  logic ok_i,
  input  logic wp_fall_i,
  input  logic wpen_i,
  input  logic busy_i,
  output logic commit_o,
  output logic abort_o
);
  sr_state_e state_q, state_d;
  logic      commit_d, abort_d;

  always_comb begin
    state_d  = state_q;
    commit_d = 1'b0;
    abort_d  = 1'b0;
    unique case (state_q)
      SR_IDLE: begin
        if (arm_i && sel_i && ok_i) state_d = SR_ARMED;
      end
      SR_ARMED: begin
        if (!sel_i) begin
          state_d  = SR_IDLE;
          commit_d = 1'b1;
        end else if (wp_fall_i && wpen_i && !busy_i) begin
          state_d = SR_IDLE;
          abort_d = 1'b1;
        end
      end
      default: state_d = SR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SR_IDLE;
      commit_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      state_q  <= state_d;
      commit_o <= commit_d;
      abort_o  <= abort_d;
    end
  end

  AST_SR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && abort_o)); // R8
  AST_COMMIT_ON_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SR_ARMED && !sel_i) |=> commit_o); // R5
  AST_NO_ABORT_WPEN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wpen_i |=> !abort_o); // R7
  AST_NO_ABORT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !abort_o); // R9
  AST_COMMIT_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(state_q == SR_ARMED)); // R5
endmodule

// File: rtl/eeprom_wr_guard.sv
module eeprom_wr_guard
  import wr_guard_pkg::*;
#(
  parameter  int unsigned DEPTH       = 8192,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wel_i,
  input  logic [1:0]        bp_i,
  input  logic              wpen_i,
  input  logic              wp_ni,
  input  logic              busy_i,
  input  logic              arr_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sr_arm_i,
  output logic              arr_allow_o,
  output logic              arr_drop_o,
  output logic              sr_allow_o,
  output logic              sr_abort_o,
  output logic              wel_clr_o
);
  logic locked, wp_lvl_n, wp_fall, hw_lock, sr_ok, arr_go, sr_try;
  logic arr_allow_q, arr_drop_q, wel_clr_q;

  wr_range_lock #(.ADDR_W(ADDR_W)) i_range (
    .lvl_i    (prot_lvl_e'(bp_i)),
    .addr_i   (addr_i),
    .locked_o (locked)
  );

  wr_pin_sync #(.STAGES(SYNC_STAGES)) i_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (wp_ni),
    .lvl_no (wp_lvl_n),
    .fall_o (wp_fall)
  );

  // pin veto only counts when the status enable bit is set
  assign hw_lock = wpen_i & ~wp_lvl_n;
  assign sr_ok   = wel_i & ~busy_i & ~hw_lock;
  assign arr_go  = arr_req_i & wel_i & ~busy_i;
  assign sr_try  = sr_arm_i & sel_i & wel_i & ~busy_i;

  wr_sr_ctrl i_sr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .arm_i     (sr_arm_i),
    .ok_i      (sr_ok),
    .wp_fall_i (wp_fall),
    .wpen_i    (wpen_i),
    .busy_i    (busy_i),
    .commit_o  (sr_allow_o),
    .abort_o   (sr_abort_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_allow_q <= 1'b0;
      arr_drop_q  <= 1'b0;
      wel_clr_q   <= 1'b0;
    end else begin
      arr_allow_q <= arr_go & ~locked;
      arr_drop_q  <= arr_go & locked;
      wel_clr_q   <= arr_go | sr_try;
    end
  end

  assign arr_allow_o = arr_allow_q;
  assign arr_drop_o  = arr_drop_q;
  assign wel_clr_o   = wel_clr_q;

  AST_ALLOW_DROP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_allow_o && arr_drop_o)); // R3
  AST_LOCK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_req_i && bp_i == 2'b11) |=> !arr_allow_o); // R3
  AST_NO_WEL_NO_ALLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_req_i && !wel_i) |=> !arr_allow_o && !wel_clr_o); // R4
  AST_BUSY_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((arr_req_i || sr_arm_i) && busy_i) |=> !arr_allow_o && !wel_clr_o); // R9
  AST_CLR_ON_ATTEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_req_i && wel_i && !busy_i) |=> wel_clr_o); // R3
  AST_OUT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_allow_o || arr_drop_o) |-> $past(arr_req_i)); // R2
endmodule

// File: tb/test_eeprom_wr_guard.sv
module test_eeprom_wr_guard;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8192;
  localparam int ADDR_W     = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic sel = 0, wel = 0, wpen = 0, wp_n = 1, busy = 0, arr_req = 0, sr_arm = 0;
  logic [1:0] bp = 0;
  logic [ADDR_W-1:0] addr = 0;
  logic arr_allow, arr_drop, sr_allow, sr_abort, wel_clr;

  int n_arr, n_drop, n_sr, n_abort, n_clr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_wr_guard #(.DEPTH(DEPTH)) i_eeprom_wr_guard (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wel_i(wel), .bp_i(bp),
    .wpen_i(wpen), .wp_ni(wp_n), .busy_i(busy), .arr_req_i(arr_req),
    .addr_i(addr), .sr_arm_i(sr_arm), .arr_allow_o(arr_allow),
    .arr_drop_o(arr_drop), .sr_allow_o(sr_allow), .sr_abort_o(sr_abort),
    .wel_clr_o(wel_clr)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      n_arr   <= n_arr + int'(arr_allow);
      n_drop  <= n_drop + int'(arr_drop);
      n_sr    <= n_sr + int'(sr_allow);
      n_abort <= n_abort + int'(sr_abort);
      n_clr   <= n_clr + int'(wel_clr);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_cnt();
    @(negedge clk);
    n_arr = 0; n_drop = 0; n_sr = 0; n_abort = 0; n_clr = 0;
  endtask

  task automatic arr_write(input logic [ADDR_W-1:0] a);
    clr_cnt();
    addr = a; arr_req = 1;
    cyc(1);
    arr_req = 0;
    cyc(3);
  endtask

  task automatic sr_open_arm();
    clr_cnt();
    sel = 1;
    cyc(1);
    sr_arm = 1;
    cyc(1);
    sr_arm = 0;
    cyc(3);
  endtask

  task automatic sr_close();
    sel = 0;
    cyc(4);
  endtask

  task automatic t_reset();
    cyc(2);
    check("R1 arr_allow", int'(arr_allow), 0);
    check("R1 sr_allow", int'(sr_allow), 0);
    check("R1 abort", int'(sr_abort), 0);
    check("R1 wel_clr", int'(wel_clr) + int'(arr_drop), 0);
    rst_n = 1;
    cyc(2);
    check("R1 post reset outputs", int'(arr_allow) + int'(sr_allow) + int'(wel_clr), 0);
  endtask

  task automatic t_arr_open();
    wel = 1; bp = 2'b00;
    arr_write(ADDR_W'(DEPTH - 1));
    check("R2 allow", n_arr, 1);
    check("R2 wel_clr", n_clr, 1);
    check("R2 no drop", n_drop, 0);
  endtask

  task automatic t_arr_levels();
    wel = 1;
    bp = 2'b01;
    arr_write(ADDR_W'(DEPTH * 3 / 4 - 1));
    check("R10 qtr edge-1 allow", n_arr, 1);
    arr_write(ADDR_W'(DEPTH * 3 / 4));
    check("R3 qtr edge allow", n_arr, 0);
    check("R3 qtr edge drop", n_drop, 1);
    check("R3 qtr edge wel_clr", n_clr, 1);
    bp = 2'b10;
    arr_write(ADDR_W'(DEPTH / 2 - 1));
    check("R10 half edge-1 allow", n_arr, 1);
    arr_write(ADDR_W'(DEPTH / 2));
    check("R3 half edge drop", n_drop, 1);
    check("R3 half edge allow", n_arr, 0);
    bp = 2'b11;
    arr_write('0);
    check("R3 all addr0 drop", n_drop, 1);
    check("R3 all wel_clr", n_clr, 1);
    bp = 2'b00;
  endtask

  task automatic t_no_wel();
    wel = 0;
    arr_write('0);
    check("R4 arr no allow", n_arr, 0);
    check("R4 arr no clr", n_clr, 0);
    sr_open_arm();
    sr_close();
    check("R4 sr no allow", n_sr, 0);
    check("R4 sr no clr", n_clr, 0);
    wel = 1;
  endtask

  task automatic t_sr_basic();
    wpen = 0; wp_n = 1; cyc(4);
    sr_open_arm();
    check("R5 no allow while selected", n_sr, 0);
    check("R5 wel_clr", n_clr, 1);
    sr_close();
    check("R5 allow after deselect", n_sr, 1);
    check("R5 no abort", n_abort, 0);
  endtask

  task automatic t_sr_locked();
    wpen = 1; wp_n = 0; cyc(4);
    sr_open_arm();
    check("R6 wel_clr on refused", n_clr, 1);
    sr_close();
    check("R6 refused", n_sr, 0);
    wp_n = 1; cyc(4);
    sr_open_arm();
    sr_close();
    check("R6 pin high allows", n_sr, 1);
  endtask

  task automatic t_wpen_off();
    wpen = 0; wp_n = 0; cyc(4);
    sr_open_arm();
    sr_close();
    check("R7 pin low ignored", n_sr, 1);
    wp_n = 1; cyc(4);
    sr_open_arm();
    wp_n = 0; cyc(5);
    check("R7 no abort", n_abort, 0);
    sr_close();
    check("R7 commit", n_sr, 1);
    wp_n = 1; cyc(4);
  endtask

  task automatic t_sr_abort();
    wpen = 1; wp_n = 1; cyc(4);
    sr_open_arm();
    wp_n = 0; cyc(5);
    check("R8 abort pulse", n_abort, 1);
    sr_close();
    check("R8 no commit", n_sr, 0);
    wp_n = 1; cyc(4);
  endtask

  task automatic t_busy();
    wpen = 1; wp_n = 1; cyc(4);
    sr_open_arm();
    sr_close();
    check("R9 commit before busy", n_sr, 1);
    busy = 1;
    clr_cnt();
    wp_n = 0; cyc(5);
    check("R9 no abort while busy", n_abort, 0);
    wp_n = 1; cyc(4);
    arr_write('0);
    check("R9 arr refused", n_arr + n_drop, 0);
    check("R9 arr no clr", n_clr, 0);
    sr_open_arm();
    sr_close();
    check("R9 sr refused", n_sr + n_clr, 0);
    busy = 0;
  endtask

  initial begin
    t_reset();
    t_arr_open();
    t_arr_levels();
    t_no_wel();
    t_sr_basic();
    t_sr_locked();
    t_wpen_off();
    t_sr_abort();
    t_busy();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule